// File: doc/BRIEF.md
# Interlaced Video Sync Input Decoder

This block sits at the timing input of a video encoder running in slave mode. It takes an external active-low horizontal sync, a second sync input that carries either an active-low vertical sync or a field level, and an optional external blank. From these it produces one-cycle field-start and frame-start strobes, an odd/even field flag, a line counter, a pixel (clock) counter and an internal blanking signal. It covers both 525-line and 625-line interlaced timing.

A two-bit mode input sets how the second sync input is read. In the two field-level modes, a change of the field level starts a field, but only when horizontal sync is at the level that mode requires. In the separate-vsync mode, the horizontal sync level at a vertical sync falling edge decides the parity of the field. When the external blank is switched off, the block blanks the standard vertical-interval lines of the selected line standard itself, and it blanks every pixel outside a configurable active window.

Top module: `sync_in_decoder`

## Requirements
- R1: While reset is asserted: field_start_o=0, frame_start_o=0, field_odd_o=0, line_o=1, pixel_o=0.
- R2: Mode 0 (field level, low qualification): a change of vsync_i while hsync_i is low starts a field. The new level 0 means an odd field, with frame_start_o set. The new level 1 means an even field. A change while hsync_i is high is ignored.
- R3: Mode 2 (field level, high qualification): the same as R2, except that only a change while hsync_i is high starts a field. A change while hsync_i is low is ignored.
- R4: Mode 1 (separate vsync): a falling edge of vsync_i while hsync_i is low starts an odd field, with frame_start_o set. A falling edge while hsync_i is high starts an even field. A rising edge is ignored.
- R5: Mode 3 decodes nothing. No field or frame strobe is produced, and field_odd_o keeps its value.
- R6: Every input passes through two synchronizer flops and one edge register. A strobe is high for exactly one cycle, on the third rising clock edge after the input change. field_odd_o updates on the same edge.
- R7: On an odd field start, line_o is set to 1. On each hsync_i falling edge that is not a field start, line_o increments, and it wraps to 1 after the last line (525 or 625). A field start overrides a coincident increment.
- R8: On each hsync_i falling edge, pixel_o is cleared to 0. It then increments every clock and saturates at its all-ones value.
- R9: With blank_en_i=0, blank_o is 1 on lines 1–21 and 263–284 in 525-line timing, and on lines 1–22 and 311–335 in 625-line timing.
- R10: With blank_en_i=0, blank_o is also 1 whenever pixel_o < ACT_START or pixel_o >= ACT_START+ACT_LEN.
- R11: With blank_en_i=1, blank_o equals blank_i delayed by two clock edges, and the line and pixel position has no effect on it.
- R12: std_625_i=0 selects 525-line timing and std_625_i=1 selects 625-line timing. An even field start sets line_o to 264 for 525-line timing and to 313 for 625-line timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Decode mode: 0 field/low, 1 separate vsync, 2 field/high, 3 off |
| std_625_i | input | 1 | 1 selects 625-line timing, 0 selects 525-line timing |
| blank_en_i | input | 1 | 1 uses the external blank; 0 uses the generated blank |
| hsync_i | input | 1 | Horizontal sync, active low |
| vsync_i | input | 1 | Vertical sync (active low) or field level, depending on mode |
| blank_i | input | 1 | External blank, active high |
| frame_start_o | output | 1 | One-cycle strobe at the start of an odd field |
| field_start_o | output | 1 | One-cycle strobe at the start of any field |
| field_odd_o | output | 1 | 1 during an odd field |
| line_o | output | 10 | Current line number, 1-based |
| pixel_o | output | PIX_W | Clocks since the last horizontal sync falling edge |
| blank_o | output | 1 | Blanking, active high |

## Verification
The hardest states to reach are the line-counter wrap and the second blanked band of each standard. Both appear only after a full field of horizontal syncs following an even-field start. To keep this affordable, the bench uses a short 20-clock line and a small pixel window, then drives a whole even field in both standards past the wrap. At every clock of every line it compares the generated blank against the line and pixel it predicts. Field edges are placed either inside or outside the low phase of horizontal sync, so each mode sees both its qualified and its ignored case, along with both parities.

// File: rtl/sdec_pkg.sv
package sdec_pkg;
  localparam int LINE_W = 10;

  typedef enum logic [1:0] {
    MODE_FLD_LO = 2'd0,
    MODE_VS_SEP = 2'd1,
    MODE_FLD_HI = 2'd2,
    MODE_OFF    = 2'd3
  } sdec_mode_e;

  function automatic logic [LINE_W-1:0] lines_total(input logic std_625);
    return std_625 ? LINE_W'(625) : LINE_W'(525);
  endfunction

  function automatic logic [LINE_W-1:0] even_first(input logic std_625);
    return std_625 ? LINE_W'(313) : LINE_W'(264);
  endfunction

  function automatic logic vbi_line(input logic std_625, input logic [LINE_W-1:0] ln);
    if (std_625)
      return (ln >= LINE_W'(1) && ln <= LINE_W'(22)) || (ln >= LINE_W'(311) && ln <= LINE_W'(335));
    else
      return (ln >= LINE_W'(1) && ln <= LINE_W'(21)) || (ln >= LINE_W'(263) && ln <= LINE_W'(284));
  endfunction
endpackage

// File: rtl/sdec_sync.sv
module sdec_sync #(
  parameter int         N       = 1,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] lvl_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= RST_VAL[i];
        s2_q <= RST_VAL[i];
      end else begin
        s1_q <= d_i[i];
        s2_q <= s1_q;
      end
    end
    assign lvl_o[i] = s2_q;
  end
endmodule

// File: rtl/sdec_field.sv
module sdec_field
  import sdec_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       hs_lvl_i,
  input  logic       fld_lvl_i,
  output logic       evt_o,
  output logic       odd_o,
  output logic       field_start_o,
  output logic       frame_start_o,
  output logic       field_odd_o
);
  logic fld_prev_q;
  logic fld_tog, fld_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fld_prev_q <= 1'b1;
    else         fld_prev_q <= fld_lvl_i;
  end

  assign fld_tog  = fld_lvl_i ^ fld_prev_q;
  assign fld_fall = fld_prev_q & ~fld_lvl_i;

  always_comb begin
    evt_o = 1'b0;
    odd_o = 1'b0;
    unique case (sdec_mode_e'(mode_i))
      MODE_FLD_LO: begin evt_o = fld_tog & ~hs_lvl_i; odd_o = ~fld_lvl_i; end
      MODE_VS_SEP: begin evt_o = fld_fall;            odd_o = ~hs_lvl_i;  end
      MODE_FLD_HI: begin evt_o = fld_tog & hs_lvl_i;  odd_o = ~fld_lvl_i; end
      default:     begin evt_o = 1'b0;                odd_o = 1'b0;       end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      field_start_o <= 1'b0;
      frame_start_o <= 1'b0;
      field_odd_o   <= 1'b0;
    end else begin
      field_start_o <= evt_o;
      frame_start_o <= evt_o & odd_o;
      if (evt_o) field_odd_o <= odd_o;
    end
  end
endmodule

// File: rtl/sdec_timing.sv
module sdec_timing
  import sdec_pkg::*;
#(
  parameter int PIX_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              std_625_i,
  input  logic              hs_fall_i,
  input  logic              fs_evt_i,
  input  logic              fs_odd_i,
  output logic [LINE_W-1:0] line_o,
  output logic [PIX_W-1:0]  pixel_o
);
  localparam logic [PIX_W-1:0] PIX_MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_o  <= LINE_W'(1);
      pixel_o <= '0;
    end else begin
      // field start wins over a coincident line step
      if (fs_evt_i)
        line_o <= fs_odd_i ? LINE_W'(1) : even_first(std_625_i);
      else if (hs_fall_i)
        line_o <= (line_o >= lines_total(std_625_i)) ? LINE_W'(1) : line_o + LINE_W'(1);

      if (hs_fall_i)              pixel_o <= '0;
      else if (pixel_o != PIX_MAX) pixel_o <= pixel_o + PIX_W'(1);
    end
  end
endmodule

// File: rtl/sdec_blank.sv
module sdec_blank
  import sdec_pkg::*;
#(
  parameter int          PIX_W     = 11,
  parameter int unsigned ACT_START = 138,
  parameter int unsigned ACT_LEN   = 1440
) (
  input  logic              std_625_i,
  input  logic              blank_en_i,
  input  logic              ext_lvl_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [PIX_W-1:0]  pixel_i,
  output logic              blank_o
);
  localparam int unsigned ACT_END = ACT_START + ACT_LEN;

  logic [31:0] pix32;
  logic        out_win;

  assign pix32   = 32'(pixel_i);
  assign out_win = (pix32 < ACT_START) || (pix32 >= ACT_END);
  assign blank_o = blank_en_i ? ext_lvl_i : (vbi_line(std_625_i, line_i) | out_win);
endmodule

// File: rtl/sync_in_decoder.sv
module sync_in_decoder
  import sdec_pkg::*;
#(
  parameter int          PIX_W     = 11,
  parameter int unsigned ACT_START = 138,
  parameter int unsigned ACT_LEN   = 1440
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              std_625_i,
  input  logic              blank_en_i,
  input  logic              hsync_i,
  input  logic              vsync_i,
  input  logic              blank_i,
  output logic              frame_start_o,
  output logic              field_start_o,
  output logic              field_odd_o,
  output logic [LINE_W-1:0] line_o,
  output logic [PIX_W-1:0]  pixel_o,
  output logic              blank_o
);
  localparam int NSYNC = 3;

  logic [NSYNC-1:0] lvl;
  logic hs_prev_q, hs_fall, fs_evt, fs_odd;

  sdec_sync #(.N(NSYNC), .RST_VAL(3'b011)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({blank_i, vsync_i, hsync_i}),
    .lvl_o (lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hs_prev_q <= 1'b1;
    else         hs_prev_q <= lvl[0];
  end
  assign hs_fall = hs_prev_q & ~lvl[0];

  sdec_field u_field (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mode_i       (mode_i),
    .hs_lvl_i     (lvl[0]),
    .fld_lvl_i    (lvl[1]),
    .evt_o        (fs_evt),
    .odd_o        (fs_odd),
    .field_start_o(field_start_o),
    .frame_start_o(frame_start_o),
    .field_odd_o  (field_odd_o)
  );

  sdec_timing #(.PIX_W(PIX_W)) u_timing (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .std_625_i(std_625_i),
    .hs_fall_i(hs_fall),
    .fs_evt_i (fs_evt),
    .fs_odd_i (fs_odd),
    .line_o   (line_o),
    .pixel_o  (pixel_o)
  );

  sdec_blank #(.PIX_W(PIX_W), .ACT_START(ACT_START), .ACT_LEN(ACT_LEN)) u_blank (
    .std_625_i (std_625_i),
    .blank_en_i(blank_en_i),
    .ext_lvl_i (lvl[2]),
    .line_i    (line_o),
    .pixel_i   (pixel_o),
    .blank_o   (blank_o)
  );
endmodule

// File: rtl/sdec_checker.sv
module sdec_checker #(
  parameter int          PIX_W     = 11,
  parameter int unsigned ACT_START = 138
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       mode_i,
  input logic             std_625_i,
  input logic             blank_en_i,
  input logic             frame_start_o,
  input logic             field_start_o,
  input logic             field_odd_o,
  input logic [9:0]       line_o,
  input logic [PIX_W-1:0] pixel_o,
  input logic             blank_o
);
  localparam logic [PIX_W-1:0] PIX_MAX = '1;

  p_frame_odd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> (field_start_o && field_odd_o));

  p_odd_line_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (field_start_o && field_odd_o) |-> (line_o == 10'd1));

  p_even_line_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (field_start_o && !field_odd_o) |-> (line_o == ($past(std_625_i) ? 10'd313 : 10'd264)));

  p_mode_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_i) == 2'd3) |-> !field_start_o);

  p_line_nonzero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_o != 10'd0);

  p_pix_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pixel_o != '0 && $past(pixel_o) != PIX_MAX) |-> (pixel_o == $past(pixel_o) + PIX_W'(1)));

  p_lead_blank_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!blank_en_i && (32'(pixel_o) < ACT_START)) |-> blank_o);
endmodule

bind sync_in_decoder sdec_checker #(.PIX_W(PIX_W), .ACT_START(ACT_START)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_i       (mode_i),
  .std_625_i    (std_625_i),
  .blank_en_i   (blank_en_i),
  .frame_start_o(frame_start_o),
  .field_start_o(field_start_o),
  .field_odd_o  (field_odd_o),
  .line_o       (line_o),
  .pixel_o      (pixel_o),
  .blank_o      (blank_o)
);

// File: tb/tb_sync_in_decoder.sv
module tb_sync_in_decoder;
  localparam int PIX_W = 5;
  localparam int AS    = 6;
  localparam int AL    = 10;
  localparam int PMAX  = (1 << PIX_W) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] mode;
  logic std, ben, hs, vs, bl;
  logic frame_s, field_s, field_odd, blank;
  logic [9:0] line;
  logic [PIX_W-1:0] pixel;

  int checks = 0;
  int errors = 0;
  int exp_line = 1;
  bit exp_odd = 1'b0;
  int bl_cnt = 0;
  logic bl_last = 1'b0;

  always #5 clk = ~clk;

  sync_in_decoder #(.PIX_W(PIX_W), .ACT_START(AS), .ACT_LEN(AL)) dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .std_625_i(std), .blank_en_i(ben),
    .hsync_i(hs), .vsync_i(vs), .blank_i(bl),
    .frame_start_o(frame_s), .field_start_o(field_s), .field_odd_o(field_odd),
    .line_o(line), .pixel_o(pixel), .blank_o(blank)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit vbi(input int ln, input bit s);
    if (s) return (ln >= 1 && ln <= 22) || (ln >= 311 && ln <= 335);
    return (ln >= 1 && ln <= 21) || (ln >= 263 && ln <= 284);
  endfunction

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'd0: return "R2";
      2'd1: return "R4";
      2'd2: return "R3";
      default: return "R5";
    endcase
  endfunction

  // one line: hsync low for clocks 0..1; optional vsync drive at clock ft
  task automatic do_line(input int len, input int ft, input logic fv);
    bit ev = 1'b0;
    bit ev_odd = 1'b0;
    for (int j = 0; j < len; j++) begin
      int t;
      if (j == 0) hs = 1'b0;
      if (j == 2) hs = 1'b1;
      if (j == ft) begin
        bit hl = (j < 2);
        bit tog = (vs != fv);
        case (mode)
          2'd0: begin ev = tog && hl;                   ev_odd = (fv == 1'b0); end
          2'd1: begin ev = (vs == 1'b1) && (fv == 1'b0); ev_odd = hl;          end
          2'd2: begin ev = tog && !hl;                  ev_odd = (fv == 1'b0); end
          default: begin ev = 1'b0; ev_odd = 1'b0; end
        endcase
        vs = fv;
      end
      bl_last = bl;
      bl_cnt++;
      bl = ((bl_cnt % 3) == 0);
      @(negedge clk);
      t = j + 1;
      if (t == 3) exp_line = (exp_line >= (std ? 625 : 525)) ? 1 : exp_line + 1;
      if (ev && t == ft + 3) begin
        exp_line = ev_odd ? 1 : (std ? 313 : 264);
        exp_odd  = ev_odd;
        chk(line == 10'(exp_line), ev_odd ? "R7" : "R12", int'(line), exp_line);
      end
      // R6: single-cycle strobes on the third edge
      chk(field_s == (ev && t == ft + 3), "R6", int'(field_s), int'(ev && t == ft + 3));
      chk(frame_s == (ev && ev_odd && t == ft + 3), mode_tag(mode), int'(frame_s),
          int'(ev && ev_odd && t == ft + 3));
      chk(field_odd == exp_odd, mode_tag(mode), int'(field_odd), int'(exp_odd));
      if (t >= 3) begin
        int ep = (t - 3 > PMAX) ? PMAX : t - 3;
        bit eb;
        string bt;
        chk(line == 10'(exp_line), "R7", int'(line), exp_line);
        chk(int'(pixel) == ep, "R8", int'(pixel), ep);
        if (ben) begin
          eb = bl_last; bt = "R11";
        end else begin
          eb = vbi(exp_line, std) || (ep < AS) || (ep >= AS + AL);
          bt = vbi(exp_line, std) ? "R9" : "R10";
        end
        chk(blank == eb, bt, int'(blank), int'(eb));
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R6: watchdog expired, actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    hs = 1'b1; vs = 1'b1; bl = 1'b0; mode = 2'd0; std = 1'b0; ben = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(field_s == 1'b0, "R1", int'(field_s), 0);
    chk(frame_s == 1'b0, "R1", int'(frame_s), 0);
    chk(field_odd == 1'b0, "R1", int'(field_odd), 0);
    chk(line == 10'd1, "R1", int'(line), 1);
    chk(pixel == '0, "R1", int'(pixel), 0);
    rst_n = 1'b1;

    repeat (3) do_line(20, -1, 1'b1);

    // mode 0: field level, hsync-low qualification
    mode = 2'd0;
    do_line(20, 1, 1'b0);
    do_line(20, -1, 1'b0);
    do_line(20, 1, 1'b1);
    do_line(20, 4, 1'b0);
    do_line(20, 1, 1'b1);
    // full 525 sweep with wrap
    do_line(20, 1, 1'b0);
    repeat (30) do_line(20, -1, 1'b0);
    do_line(20, 1, 1'b1);
    repeat (265) do_line(20, -1, 1'b1);

    // mode 2: hsync-high qualification
    mode = 2'd2;
    do_line(20, 4, 1'b0);
    do_line(20, 1, 1'b1);
    do_line(20, 4, 1'b0);
    do_line(20, 4, 1'b1);

    // mode 1: separate vsync
    mode = 2'd1;
    do_line(20, 1, 1'b0);
    do_line(20, 6, 1'b1);
    do_line(20, 4, 1'b0);
    do_line(20, 1, 1'b1);

    // mode 3: decoding off
    mode = 2'd3;
    do_line(20, 1, 1'b0);
    do_line(20, 4, 1'b1);
    do_line(20, 1, 1'b0);

    // 625-line timing, full sweep with wrap
    std = 1'b1;
    mode = 2'd1;
    do_line(20, 4, 1'b1);
    do_line(20, 1, 1'b0);
    repeat (30) do_line(20, -1, 1'b0);
    do_line(20, 4, 1'b1);
    do_line(20, 4, 1'b0);
    repeat (316) do_line(20, -1, 1'b0);

    // external blank
    ben = 1'b1;
    repeat (4) do_line(20, -1, 1'b0);
    ben = 1'b0;

    // long line: pixel saturation
    do_line(45, -1, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule